// File: doc/BRIEF.md
# Latched Fault and Alert Aggregator

This block collects protection conditions from a battery monitor and holds them until the host has seen them. The fault conditions are per-cell over-voltage, per-cell under-voltage and two over-temperature inputs. The alert conditions are a separate set of inputs. Each condition arrives as a digital level or pulse; threshold comparison happens upstream. Every condition sets its own sticky flag, either in the fault flag register or in the alert flag register.

Each flag register is OR-reduced into a summary bit in a device status word. Each summary bit drives a hardware pin directly, so an external controller can react without a host transaction. A small state machine runs each summary bit. `SUM_IDLE` moves to `SUM_ACTIVE` when any flag will be set after the edge. `SUM_ACTIVE` moves to `SUM_HELD` once every flag is clear. `SUM_HELD` returns to `SUM_ACTIVE` when a flag sets again, or falls to `SUM_IDLE` when the host writes the status clear. The pin is high in every state except `SUM_IDLE`.

The host reads the registers through a combinational read port. It clears bits with write-1-to-clear writes on a single-cycle write strobe.

Top module: `fault_alert_latch`

## Requirements
- R1: After reset, both flag registers, both summary bits and both pins are zero.
- R2: A fault condition that is high in any cycle sets its flag at the next clock edge, and the flag stays set after the condition drops. The fault flag register holds over-voltage of cell i at bit i, under-voltage of cell i at bit NUM_CELLS+i, and over-temperature input j at bit 2*NUM_CELLS+j.
- R3: Alert input k that is high in any cycle sets bit k of the alert flag register at the next edge, and the bit stays set.
- R4: A write to address 0 (fault flags) or address 1 (alert flags) clears exactly the flag bits written as 1 and leaves the other bits untouched.
- R5: When a condition is present in the same cycle as a write that clears its flag, the flag is set after the edge.
- R6: Status bit 0 and fault_pin go high at the same edge at which any fault flag becomes set.
- R7: Status bit 1 and alert_pin go high at the same edge at which any alert flag becomes set.
- R8: A summary bit and its pin stay high after their flags are cleared, and fall only when 1 is written to their status bit at address 2 while no flag of that register is set or being set. Such a write has no effect while any of those flags is set.
- R9: Reads return the fault flags at address 0, the alert flags at address 1, {alert summary, fault summary} in bits 1:0 at address 2, and zero at address 3. Unused upper bits read as zero.
- R10: A write to address 3 changes no flag, summary bit or pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ov_cond | input | NUM_CELLS | Per-cell over-voltage conditions |
| uv_cond | input | NUM_CELLS | Per-cell under-voltage conditions |
| ot_cond | input | 2 | Over-temperature conditions |
| alert_cond | input | NUM_ALERTS | Alert conditions |
| wr_en | input | 1 | Single-cycle write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | DATA_W | Write data; 1 bits clear |
| rd_addr | input | 2 | Read address |
| rd_data | output | DATA_W | Read data (combinational) |
| fault_pin | output | 1 | Latched fault summary pin |
| alert_pin | output | 1 | Latched alert summary pin |

## Verification
The hardest state to reach is `SUM_HELD`, followed by a status clear that competes with a fault condition appearing again. The flags must first be cleared through their own address. A condition must then be raised in exactly the cycle of the status write. The stimulus builds this sequence step by step: pulse, clear the flags, then clear the status with and without a competing pulse. A same-cycle set-and-clear phase and a random phase follow, with the read address cycling through all four locations, so that every register is compared against the model on every clock.

// File: rtl/fault_alert_pkg.sv
package fault_alert_pkg;
    typedef enum logic [1:0] {
        SUM_IDLE   = 2'd0,
        SUM_ACTIVE = 2'd1,
        SUM_HELD   = 2'd2
    } sum_state_t;

    localparam logic [1:0] ADDR_FAULT  = 2'd0;
    localparam logic [1:0] ADDR_ALERT  = 2'd1;
    localparam logic [1:0] ADDR_STATUS = 2'd2;
endpackage

// File: rtl/sticky_flags.sv
module sticky_flags #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic         clr_i,
    input  logic [W-1:0] mask_i,
    output logic [W-1:0] flags_o,
    output logic [W-1:0] next_o
);
    logic [W-1:0] clr_vec;

    always_comb begin
        clr_vec = clr_i ? mask_i : '0;
        // set has priority over clear in the same cycle
        next_o  = (flags_o & ~clr_vec) | set_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flags_o <= '0;
        else        flags_o <= next_o;
    end
endmodule

// File: rtl/summary_fsm.sv
module summary_fsm
    import fault_alert_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic any_next_i,
    input  logic clr_i,
    output logic latched_o
);
    sum_state_t state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            SUM_IDLE:   state_nx = any_next_i ? SUM_ACTIVE : SUM_IDLE;
            SUM_ACTIVE: state_nx = any_next_i ? SUM_ACTIVE : SUM_HELD;
            SUM_HELD: begin
                if (any_next_i) state_nx = SUM_ACTIVE;
                else if (clr_i) state_nx = SUM_IDLE;
                else            state_nx = SUM_HELD;
            end
            default:    state_nx = SUM_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= SUM_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        latched_o = (state != SUM_IDLE);
    end
endmodule

// File: rtl/fault_alert_latch.sv
module fault_alert_latch
    import fault_alert_pkg::*;
#(
    parameter int NUM_CELLS  = 6,
    parameter int NUM_ALERTS = 4,
    parameter int DATA_W     = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_CELLS-1:0]  ov_cond,
    input  logic [NUM_CELLS-1:0]  uv_cond,
    input  logic [1:0]            ot_cond,
    input  logic [NUM_ALERTS-1:0] alert_cond,
    input  logic                  wr_en,
    input  logic [1:0]            wr_addr,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic [1:0]            rd_addr,
    output logic [DATA_W-1:0]     rd_data,
    output logic                  fault_pin,
    output logic                  alert_pin
);
    localparam int FW = 2 * NUM_CELLS + 2;
    localparam int AW = NUM_ALERTS;

    logic [FW-1:0] fault_in, fault_flags, fault_next;
    logic [AW-1:0] alert_flags, alert_next;
    logic          clr_fault, clr_alert, clr_fsum, clr_asum;

    assign fault_in  = {ot_cond, uv_cond, ov_cond};
    assign clr_fault = wr_en && (wr_addr == ADDR_FAULT);
    assign clr_alert = wr_en && (wr_addr == ADDR_ALERT);
    assign clr_fsum  = wr_en && (wr_addr == ADDR_STATUS) && wr_data[0];
    assign clr_asum  = wr_en && (wr_addr == ADDR_STATUS) && wr_data[1];

    sticky_flags #(.W(FW)) u_fault_flags (
        .clk(clk), .rst_n(rst_n), .set_i(fault_in), .clr_i(clr_fault),
        .mask_i(wr_data[FW-1:0]), .flags_o(fault_flags), .next_o(fault_next)
    );

    sticky_flags #(.W(AW)) u_alert_flags (
        .clk(clk), .rst_n(rst_n), .set_i(alert_cond), .clr_i(clr_alert),
        .mask_i(wr_data[AW-1:0]), .flags_o(alert_flags), .next_o(alert_next)
    );

    summary_fsm u_fault_sum (
        .clk(clk), .rst_n(rst_n), .any_next_i(|fault_next),
        .clr_i(clr_fsum), .latched_o(fault_pin)
    );

    summary_fsm u_alert_sum (
        .clk(clk), .rst_n(rst_n), .any_next_i(|alert_next),
        .clr_i(clr_asum), .latched_o(alert_pin)
    );

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            ADDR_FAULT:  rd_data[FW-1:0] = fault_flags;
            ADDR_ALERT:  rd_data[AW-1:0] = alert_flags;
            ADDR_STATUS: rd_data[1:0]    = {alert_pin, fault_pin};
            default:     rd_data         = '0;
        endcase
    end
endmodule

// File: rtl/fault_alert_latch_chk.sv
module fault_alert_latch_chk #(
    parameter int NUM_CELLS  = 6,
    parameter int NUM_ALERTS = 4,
    parameter int DATA_W     = 16
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [NUM_CELLS-1:0]      ov_cond,
    input logic [NUM_CELLS-1:0]      uv_cond,
    input logic [1:0]                ot_cond,
    input logic [NUM_ALERTS-1:0]     alert_cond,
    input logic                      wr_en,
    input logic [1:0]                wr_addr,
    input logic [DATA_W-1:0]         wr_data,
    input logic [1:0]                rd_addr,
    input logic [DATA_W-1:0]         rd_data,
    input logic                      fault_pin,
    input logic                      alert_pin,
    input logic [2*NUM_CELLS+1:0]    fault_flags,
    input logic [NUM_ALERTS-1:0]     alert_flags
);
    localparam int FW = 2 * NUM_CELLS + 2;
    logic [FW-1:0] fin;
    assign fin = {ot_cond, uv_cond, ov_cond};

    // R2
    fault_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fin != '0) |=> ((fault_flags & $past(fin)) == $past(fin)));

    // R3
    alert_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alert_cond != '0) |=> ((alert_flags & $past(alert_cond)) == $past(alert_cond)));

    // R4
    flag_clear_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(fault_flags) & ~fault_flags) != '0) |-> $past(wr_en && wr_addr == 2'd0));

    // R5
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd0 && ((fin & wr_data[FW-1:0]) != '0))
        |=> ((fault_flags & $past(fin)) == $past(fin)));

    // R6
    fault_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_flags != '0) |-> fault_pin);

    // R7
    alert_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alert_flags != '0) |-> alert_pin);

    // R8
    fault_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fault_pin) |-> $past(wr_en && wr_addr == 2'd2 && wr_data[0]));

    // R8
    alert_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(alert_pin) |-> $past(wr_en && wr_addr == 2'd2 && wr_data[1]));

    // R9
    status_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == 2'd2) |-> (rd_data[1:0] == {alert_pin, fault_pin}));
endmodule

bind fault_alert_latch fault_alert_latch_chk #(
    .NUM_CELLS(NUM_CELLS), .NUM_ALERTS(NUM_ALERTS), .DATA_W(DATA_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ov_cond(ov_cond), .uv_cond(uv_cond),
    .ot_cond(ot_cond), .alert_cond(alert_cond), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .fault_pin(fault_pin), .alert_pin(alert_pin),
    .fault_flags(fault_flags), .alert_flags(alert_flags)
);

// File: tb/fault_alert_latch_bench.sv
module fault_alert_latch_bench;
    localparam int NC = 6;
    localparam int NA = 4;
    localparam int DW = 16;
    localparam int FW = 2 * NC + 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NC-1:0] ov_cond = '0, uv_cond = '0;
    logic [1:0]    ot_cond = '0;
    logic [NA-1:0] alert_cond = '0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [1:0]    rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic          fault_pin, alert_pin;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    fault_alert_latch #(.NUM_CELLS(NC), .NUM_ALERTS(NA), .DATA_W(DW)) u_fault_alert_latch (
        .clk(clk), .rst_n(rst_n), .ov_cond(ov_cond), .uv_cond(uv_cond),
        .ot_cond(ot_cond), .alert_cond(alert_cond), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .fault_pin(fault_pin), .alert_pin(alert_pin)
    );

    // behavioural reference state
    bit [FW-1:0] m_fault;
    bit [NA-1:0] m_alert;
    bit          m_fsum, m_asum;

    always @(posedge clk) begin
        bit [FW-1:0] fin;
        fin = {ot_cond, uv_cond, ov_cond};
        if (!rst_n) begin
            m_fault = '0; m_alert = '0; m_fsum = 0; m_asum = 0;
        end else begin
            if (wr_en && wr_addr == 2'd0) m_fault = m_fault & ~wr_data[FW-1:0];
            if (wr_en && wr_addr == 2'd1) m_alert = m_alert & ~wr_data[NA-1:0];
            m_fault = m_fault | fin;
            m_alert = m_alert | alert_cond;
            m_fsum = (m_fault != 0) || (m_fsum && !(wr_en && wr_addr == 2'd2 && wr_data[0]));
            m_asum = (m_alert != 0) || (m_asum && !(wr_en && wr_addr == 2'd2 && wr_data[1]));
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic compare(input string req);
        int exp;
        case (rd_addr)
            2'd0:    exp = int'(m_fault);
            2'd1:    exp = int'(m_alert);
            2'd2:    exp = int'({m_asum, m_fsum});
            default: exp = 0;
        endcase
        check(req, "fault_pin", int'(fault_pin), int'(m_fsum));
        check(req, "alert_pin", int'(alert_pin), int'(m_asum));
        check(req, $sformatf("rd_data@%0d", rd_addr), int'(rd_data), exp);
    endtask

    task automatic cyc(input string req);
        @(negedge clk);
        compare(req);
        rd_addr = rd_addr + 2'd1;
        wr_en = 1'b0; ov_cond = '0; uv_cond = '0; ot_cond = '0; alert_cond = '0;
    endtask

    task automatic host_wr(input logic [1:0] a, input logic [DW-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
    endtask

    task automatic idle(input string req, input int n);
        for (int i = 0; i < n; i++) cyc(req);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R1: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state on every register
        idle("R1", 4);
        // R2: single-cycle pulses on each fault class
        for (int i = 0; i < NC; i++) begin ov_cond[i] = 1'b1; cyc("R2"); idle("R2", 1); end
        for (int i = 0; i < NC; i++) begin uv_cond[i] = 1'b1; cyc("R6"); end
        ot_cond = 2'b10; cyc("R2"); ot_cond = 2'b01; cyc("R2"); idle("R2", 4);
        // R3: alert pulses
        for (int i = 0; i < NA; i++) begin alert_cond[i] = 1'b1; cyc("R3"); end
        idle("R7", 4);
        // R4: partial clears
        host_wr(2'd0, 16'h0055); cyc("R4"); idle("R4", 4);
        host_wr(2'd1, 16'h0005); cyc("R4"); idle("R4", 4);
        // R8: status clear while flags remain is ignored
        host_wr(2'd2, 16'h0003); cyc("R8"); idle("R8", 4);
        // R10: address 3 writes are inert
        host_wr(2'd3, 16'hFFFF); cyc("R10"); idle("R10", 4);
        // R5: set and clear in the same cycle
        host_wr(2'd0, 16'h3FFF); ov_cond = 6'h01; ot_cond = 2'b10; cyc("R5"); idle("R5", 4);
        host_wr(2'd1, 16'h000F); alert_cond = 4'h8; cyc("R5"); idle("R5", 4);
        // R8: clear all flags, summaries held, then clear status with a competing pulse
        host_wr(2'd0, 16'hFFFF); cyc("R8");
        host_wr(2'd1, 16'hFFFF); cyc("R8"); idle("R8", 4);
        host_wr(2'd2, 16'h0001); uv_cond = 6'h20; cyc("R8"); idle("R8", 4);
        host_wr(2'd0, 16'hFFFF); cyc("R8"); idle("R8", 2);
        host_wr(2'd2, 16'h0001); cyc("R8"); idle("R8", 4);
        host_wr(2'd2, 16'h0002); cyc("R8"); idle("R9", 4);
        // R9 and random traffic
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(0, 7) == 0) ov_cond = NC'($urandom);
            if ($urandom_range(0, 7) == 0) uv_cond = NC'($urandom);
            if ($urandom_range(0, 15) == 0) ot_cond = 2'($urandom);
            if ($urandom_range(0, 7) == 0) alert_cond = NA'($urandom);
            if ($urandom_range(0, 2) == 0) host_wr(2'($urandom), DW'($urandom));
            cyc("R9");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule